// File: doc/BRIEF.md
# Odd-Ratio Clock Divider with Balanced Duty Cycle

This block takes a clock and produces a slower clock whose period is an odd number N of input periods, and whose high and low phases are exactly equal, each N/2 input periods long. A plain counter or state machine can only switch the output on rising input edges. For an odd ratio that gives an uneven duty cycle, because each phase must last a whole number of input periods.

The block avoids that limit with one modulo-N counter on the rising edge and two single-bit toggle registers. One toggle register updates on the rising edge and the other on the falling edge, and each is enabled at a different counter value. The output is the exclusive-OR of the two. It therefore rises on a rising input edge and falls on a falling input edge, half an input period later than a counter alone could manage.

The ratio N is a parameter, 3 by default. It must be odd and at least 3, and any other value stops elaboration. Reset is synchronous and active high.

Top module: `odd_clk_div`

## Requirements
- R1: The phase counter takes the values 0 to N-1 in order, one step per rising input edge, and returns to 0 after N-1.
- R2: The rising-edge toggle register inverts at a rising input edge exactly when the counter holds 0 just before that edge. The first output rise after reset release therefore comes at the first rising edge that samples reset low.
- R3: The falling-edge toggle register inverts at a falling input edge exactly when the counter holds (N+1)/2, which is 2 for N = 3.
- R4: The output clock is the exclusive-OR of the two toggle registers, so every output edge follows one toggle event.
- R5: Every high phase of the output lasts N/2 input periods, for example 6 ns for N = 3 with a 4 ns input period.
- R6: Every low phase of the output lasts N/2 input periods, so the output period is N input periods.
- R7: While reset is held over at least one rising and one falling input edge, the counter is 0, both toggle registers are 0 and the output is low.
- R8: A reset applied during operation, whatever the output phase, restarts the sequence: after release the output rises at the first rising edge that samples reset low, and the duty cycle is balanced again from that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| clk_out | output | 1 | Divided clock, period N input periods, 50% duty |

## Verification
Three instances run side by side, with ratios 3, 5 and 7, so any hard-coded phase shows up as a wrong high or low time on at least one ratio. Every output phase is timed against the input period. A wrong falling-edge decode makes the high and low times unequal, and a missing exclusive-OR or toggle makes the period wrong. A reset while running, applied at a different phase for each ratio, separates a clean restart from a leftover falling-edge state. The time of the first rise after each release pins down the rising-edge enable.

// File: rtl/odd_div_pkg.sv
`timescale 1ns/1ps
package odd_div_pkg;

    // Counter value at which the falling-edge toggle fires.
    function automatic int fall_phase(input int ratio);
        return (ratio + 1) / 2;
    endfunction

    // Only odd ratios of three or more give a balanced output.
    function automatic bit ratio_ok(input int ratio);
        return (ratio >= 3) && ((ratio % 2) == 1);
    endfunction

endpackage

// File: rtl/div_phase_counter.sv
`timescale 1ns/1ps
module div_phase_counter #(
    parameter int N  = 3,
    parameter int CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output logic          rise_en,
    output logic          fall_en
);
    import odd_div_pkg::*;

    localparam logic [CW-1:0] LAST   = CW'(N - 1);
    localparam logic [CW-1:0] F_STEP = CW'(fall_phase(N));

    typedef struct packed {
        logic [CW-1:0] cnt;
    } phase_state_t;

    phase_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign rise_en = (st_q.cnt == '0);
    assign fall_en = (st_q.cnt == F_STEP);

endmodule

// File: rtl/div_toggle_ff.sv
`timescale 1ns/1ps
module div_toggle_ff #(
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic q
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q ^ en;
        if (rst) begin
            tog_d = 1'b0;
        end
    end

    generate
        if (FALL_EDGE) begin : g_fall
            always_ff @(negedge clk) begin
                tog_q <= tog_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                tog_q <= tog_d;
            end
        end
    endgenerate

    assign q = tog_q;

endmodule

// File: rtl/odd_clk_div.sv
`timescale 1ns/1ps
module odd_clk_div #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst,
    output logic clk_out
);
    import odd_div_pkg::*;

    localparam int CW = $clog2(N);

    generate
        if (!ratio_ok(N)) begin : g_bad_ratio
            $error("odd_clk_div: N must be odd and at least 3");
        end
    endgenerate

    logic [CW-1:0] cnt_q;
    logic          rise_en, fall_en;
    logic          rise_q, fall_q;

    div_phase_counter #(.N(N), .CW(CW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt_q),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    div_toggle_ff #(.FALL_EDGE(1'b0)) u_tog_rise (
        .clk (clk),
        .rst (rst),
        .en  (rise_en),
        .q   (rise_q)
    );

    div_toggle_ff #(.FALL_EDGE(1'b1)) u_tog_fall (
        .clk (clk),
        .rst (rst),
        .en  (fall_en),
        .q   (fall_q)
    );

    assign clk_out = rise_q ^ fall_q;

endmodule

// File: rtl/odd_clk_div_chk.sv
`timescale 1ns/1ps
module odd_clk_div_chk #(
    parameter int N  = 3,
    parameter int CW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cnt_q,
    input logic          rise_q,
    input logic          fall_q,
    input logic          clk_out
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);
    localparam logic [CW-1:0] HALF = CW'((N + 1) / 2);

    p_count_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_count_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));

    p_rise_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |=> (rise_q != $past(rise_q)));

    p_rise_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> $stable(rise_q));

    p_fall_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cnt_q == HALF) |-> (fall_q != $past(fall_q)));

    p_fall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cnt_q != HALF) |-> $stable(fall_q));

    p_reset_clear_r7: assert property (@(posedge clk)
        $past(rst) |-> (cnt_q == '0 && !rise_q));

    p_reset_low_r7: assert property (@(posedge clk)
        ($past(rst) && rst) |-> !clk_out);

endmodule

bind odd_clk_div odd_clk_div_chk #(.N(N), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_q   (cnt_q),
    .rise_q  (rise_q),
    .fall_q  (fall_q),
    .clk_out (clk_out)
);

// File: tb/test_odd_clk_div.sv
`timescale 1ns/1ps
module test_odd_clk_div;

    localparam real T_CLK = 4.0;

    logic clk = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #(T_CLK / 2.0) clk = ~clk;

    task automatic check(input bit ok, input string req, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
        end
    endtask

    for (genvar gi = 0; gi < 3; gi++) begin : g_dut
        localparam int NV = 3 + 2 * gi;
        localparam real HALF_T = NV * T_CLK / 2.0;

        logic rst_b = 1'b1;
        logic dv;
        logic done = 1'b0;
        logic armed = 1'b0;
        logic first_pend = 1'b0;
        real  t_last = 0.0;
        real  exp_first = 0.0;
        real  exp_q[$];

        odd_clk_div #(.N(NV)) i_odd_clk_div (
            .clk     (clk),
            .rst     (rst_b),
            .clk_out (dv)
        );

        // driver: pushes expected phase lengths
        task automatic push_pairs(input int k);
            for (int j = 0; j < k; j++) begin
                exp_q.push_back(HALF_T);
                exp_q.push_back(HALF_T);
            end
        endtask

        task automatic release_rst(input int k);
            @(posedge clk);
            #1;
            rst_b = 1'b0;
            exp_first = $realtime - 1.0 + T_CLK;
            first_pend = 1'b1;
            push_pairs(k);
            while (exp_q.size() != 0) @(posedge clk);
        endtask

        initial begin
            repeat (3) @(posedge clk);
            #1;
            check(dv == 1'b0, $sformatf("R7 N=%0d low in reset", NV), real'(dv), 0.0);
            release_rst(6);
            // mid-run reset at a ratio-dependent phase
            repeat (gi + 1) @(posedge clk);
            #1;
            rst_b = 1'b1;
            exp_q.delete();
            repeat (2) @(posedge clk);
            #1;
            check(dv == 1'b0, $sformatf("R7 N=%0d low after mid-run reset", NV), real'(dv), 0.0);
            release_rst(4);
            done = 1'b1;
        end

        // monitor: times every output phase
        always @(posedge dv or negedge dv or posedge rst_b) begin
            if (rst_b) begin
                armed = 1'b0;
            end else if (!armed) begin
                if (dv) begin
                    if (first_pend) begin
                        check(($realtime - exp_first) < 0.001 && (exp_first - $realtime) < 0.001,
                              $sformatf("R2 R8 N=%0d first rise", NV), $realtime, exp_first);
                        first_pend = 1'b0;
                    end
                    armed  = 1'b1;
                    t_last = $realtime;
                end
            end else begin
                if (exp_q.size() > 0) begin
                    real e, got;
                    e   = exp_q.pop_front();
                    got = $realtime - t_last;
                    check((got - e) < 0.001 && (e - got) < 0.001,
                          dv ? $sformatf("R6 R4 N=%0d low time", NV)
                             : $sformatf("R5 R3 N=%0d high time", NV),
                          got, e);
                end
                t_last = $realtime;
            end
        end
    end

    initial begin
        wait (g_dut[0].done && g_dut[1].done && g_dut[2].done);
        #1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000.0 * T_CLK);
        check(1'b0, "watchdog expired", $realtime, 0.0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule